// File: doc/BRIEF.md
# Fully Associative Translation Lookaside Buffer

This block keeps recently used page-number to frame-number translations so that most memory accesses do not need a page-table read. On a lookup, the requested page number is compared against every occupied entry at the same time. A hit returns three items from the matching entry: the frame number, the page-valid bit and the read/write/execute permission bits. A miss tells the requester to fetch the translation from the page table. The requester then installs the fetched translation through the fill port.

The lookup result is formed combinationally from the current contents and registered, so it appears one clock after the request. A fill first reuses an entry that already holds the same page number. Otherwise it takes the lowest-numbered unoccupied entry. If every entry is occupied, it evicts the entry named by a round-robin pointer. A single-cycle flush empties the whole buffer, for example on a context switch.

Top module: `tlb_fa`

## Requirements
- R1: After reset every entry is unoccupied and all outputs are zero, so any lookup misses until a fill is made.
- R2: `resp_valid_o` is high in the cycle after `lookup_valid_i` was high and low otherwise. The response reflects the contents held before that clock edge, so a fill made in the same cycle as a lookup is not seen by that lookup.
- R3: A hit returns the stored frame number, the page-valid bit and the permissions of the matching entry (bit 2 read, bit 1 write, bit 0 execute). An entry whose page-valid bit is 0 still hits and returns `resp_pv_o` = 0.
- R4: When a lookup misses, or when no lookup was made, `resp_hit_o`, `resp_pfn_o`, `resp_pv_o` and `resp_perm_o` are all zero.
- R5: A fill of a page number that is not present, while at least one entry is unoccupied, writes the lowest-numbered unoccupied entry. No existing translation is lost.
- R6: A fill of a new page number into a full buffer replaces the entry at the round-robin pointer. The pointer is 0 after reset and advances by one only on such a replacement, wrapping from ENTRIES-1 to 0.
- R7: A fill whose page number is already present overwrites that entry in place. It creates no duplicate and does not move the round-robin pointer.
- R8: A flush makes every entry unoccupied in one cycle. A fill in the same cycle is dropped, and the round-robin pointer keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lookup_valid_i | input | 1 | Lookup request |
| lookup_vpn_i | input | VPN_W | Page number to translate |
| resp_valid_o | output | 1 | Registered response valid |
| resp_hit_o | output | 1 | Translation was found |
| resp_pfn_o | output | PFN_W | Frame number on a hit |
| resp_pv_o | output | 1 | Page-valid bit on a hit |
| resp_perm_o | output | 3 | Read/write/execute bits on a hit |
| fill_i | input | 1 | Install a translation |
| fill_vpn_i | input | VPN_W | Page number being installed |
| fill_pfn_i | input | PFN_W | Frame number being installed |
| fill_pv_i | input | 1 | Page-valid bit being installed |
| fill_perm_i | input | 3 | Permission bits being installed |
| flush_i | input | 1 | Empty every entry |

## Verification
The bench fills the buffer from empty to full and checks the placement. A victim chooser that skipped a free slot would evict a live translation, and later lookups would miss where hits were expected. Replacements are run past a full wrap of the pointer, and refills of resident pages are mixed in. A pointer that moved on a refill, or a refill that made a second copy, shifts the later evictions to the wrong entries. Lookups placed in the same cycle as a fill, and flushes placed in the same cycle as a fill, catch a design that forwards fill data into the response or lets a fill survive a flush. A long random phase over a small page-number range makes hits, refills and evictions frequent.

// File: rtl/tlb_fa_pkg.sv
package tlb_fa_pkg;
  localparam int PERM_W = 3;

  typedef struct packed {
    logic r;
    logic w;
    logic x;
  } perm_t;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N     = 32,
  parameter int VPN_W = 20,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]            occ_i,
  input  logic [N-1:0][VPN_W-1:0] tags_i,
  input  logic [VPN_W-1:0]        key_i,
  output logic [N-1:0]            match_o,
  output logic                    any_o,
  output logic [IDX_W-1:0]        idx_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_o[g] = occ_i[g] && (tags_i[g] == key_i);
  end

  assign any_o = |match_o;

  // match is at most one-hot, so OR-encoding gives the index
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (match_o[i]) idx_o = idx_o | IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N = 32,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     occ_i,
  input  logic             repl_en_i,
  output logic             full_o,
  output logic [IDX_W-1:0] free_idx_o,
  output logic [IDX_W-1:0] rr_o
);
  logic [IDX_W-1:0] rr_q;

  assign full_o = &occ_i;
  assign rr_o   = rr_q;

  // lowest unoccupied slot
  always_comb begin
    free_idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!occ_i[i]) free_idx_o = IDX_W'(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rr_q <= '0;
    end else if (repl_en_i) begin
      rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
    end
  end

  assert_rr_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !repl_en_i |=> $stable(rr_q));
  assert_rr_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    repl_en_i && (rr_q != IDX_W'(N - 1)) |=> rr_q == $past(rr_q) + 1'b1);
endmodule

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_fa_pkg::*;
#(
  parameter int N     = 32,
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  localparam int IDX_W = $clog2(N)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    flush_i,
  input  logic                    we_i,
  input  logic [IDX_W-1:0]        widx_i,
  input  logic [VPN_W-1:0]        wvpn_i,
  input  logic [PFN_W-1:0]        wpfn_i,
  input  logic                    wpv_i,
  input  perm_t                   wperm_i,
  input  logic [IDX_W-1:0]        ridx_i,
  output logic [PFN_W-1:0]        rpfn_o,
  output logic                    rpv_o,
  output perm_t                   rperm_o,
  output logic [N-1:0]            occ_o,
  output logic [N-1:0][VPN_W-1:0] tags_o
);
  logic [N-1:0]            occ_q;
  logic [N-1:0][VPN_W-1:0] vpn_q;
  logic [N-1:0][PFN_W-1:0] pfn_q;
  logic [N-1:0]            pv_q;
  perm_t [N-1:0]           perm_q;

  for (genvar g = 0; g < N; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        occ_q[g]  <= 1'b0;
        vpn_q[g]  <= '0;
        pfn_q[g]  <= '0;
        pv_q[g]   <= 1'b0;
        perm_q[g] <= '0;
      end else if (flush_i) begin
        occ_q[g] <= 1'b0;
      end else if (we_i && (widx_i == IDX_W'(g))) begin
        occ_q[g]  <= 1'b1;
        vpn_q[g]  <= wvpn_i;
        pfn_q[g]  <= wpfn_i;
        pv_q[g]   <= wpv_i;
        perm_q[g] <= wperm_i;
      end
    end
  end

  assign occ_o   = occ_q;
  assign tags_o  = vpn_q;
  assign rpfn_o  = pfn_q[ridx_i];
  assign rpv_o   = pv_q[ridx_i];
  assign rperm_o = perm_q[ridx_i];

  assert_flush_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> occ_q == '0);
  assert_fill_occupies_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && !flush_i |=> occ_q[$past(widx_i)]);
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
  import tlb_fa_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lookup_valid_i,
  input  logic [VPN_W-1:0]  lookup_vpn_i,
  output logic              resp_valid_o,
  output logic              resp_hit_o,
  output logic [PFN_W-1:0]  resp_pfn_o,
  output logic              resp_pv_o,
  output logic [PERM_W-1:0] resp_perm_o,
  input  logic              fill_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [PFN_W-1:0]  fill_pfn_i,
  input  logic              fill_pv_i,
  input  logic [PERM_W-1:0] fill_perm_i,
  input  logic              flush_i
);
  logic [ENTRIES-1:0]            occ;
  logic [ENTRIES-1:0][VPN_W-1:0] tags;
  logic [ENTRIES-1:0]            lk_match, fl_match;
  logic                          lk_hit, fl_hit, full;
  logic [IDX_W-1:0]              lk_idx, fl_idx, free_idx, rr_idx, wr_idx;
  logic [PFN_W-1:0]              rd_pfn;
  logic                          rd_pv;
  perm_t                         rd_perm;
  logic                          wr_en, repl_en, hit_d;

  tlb_match #(.N(ENTRIES), .VPN_W(VPN_W)) u_lk_match (
    .occ_i(occ), .tags_i(tags), .key_i(lookup_vpn_i),
    .match_o(lk_match), .any_o(lk_hit), .idx_o(lk_idx)
  );

  tlb_match #(.N(ENTRIES), .VPN_W(VPN_W)) u_fl_match (
    .occ_i(occ), .tags_i(tags), .key_i(fill_vpn_i),
    .match_o(fl_match), .any_o(fl_hit), .idx_o(fl_idx)
  );

  assign wr_en   = fill_i && !flush_i;
  assign repl_en = wr_en && !fl_hit && full;

  always_comb begin
    if (fl_hit)    wr_idx = fl_idx;
    else if (full) wr_idx = rr_idx;
    else           wr_idx = free_idx;
  end

  tlb_victim #(.N(ENTRIES)) u_victim (
    .clk_i(clk_i), .rst_ni(rst_ni), .occ_i(occ), .repl_en_i(repl_en),
    .full_o(full), .free_idx_o(free_idx), .rr_o(rr_idx)
  );

  tlb_store #(.N(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .flush_i(flush_i),
    .we_i(wr_en), .widx_i(wr_idx), .wvpn_i(fill_vpn_i), .wpfn_i(fill_pfn_i),
    .wpv_i(fill_pv_i), .wperm_i(perm_t'(fill_perm_i)),
    .ridx_i(lk_idx), .rpfn_o(rd_pfn), .rpv_o(rd_pv), .rperm_o(rd_perm),
    .occ_o(occ), .tags_o(tags)
  );

  assign hit_d = lookup_valid_i && lk_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      resp_hit_o   <= 1'b0;
      resp_pfn_o   <= '0;
      resp_pv_o    <= 1'b0;
      resp_perm_o  <= '0;
    end else begin
      resp_valid_o <= lookup_valid_i;
      resp_hit_o   <= hit_d;
      resp_pfn_o   <= hit_d ? rd_pfn : '0;
      resp_pv_o    <= hit_d ? rd_pv : 1'b0;
      resp_perm_o  <= hit_d ? PERM_W'(rd_perm) : '0;
    end
  end

  assert_resp_follows_lookup_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_valid_i |=> resp_valid_o);
  assert_no_resp_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_valid_i |=> !resp_valid_o && !resp_hit_o);
  assert_no_dup_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_match) && $onehot0(fl_match));
  assert_miss_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !resp_hit_o |-> (resp_pfn_o == '0) && !resp_pv_o && (resp_perm_o == '0));
  assert_fill_free_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en && !fl_hit && !full |-> !occ[wr_idx]);
endmodule

// File: tb/tlb_fa_tb_top.sv
`timescale 1ns/1ps
module tlb_fa_tb_top;
  localparam int N     = 32;
  localparam int VPN_W = 20;
  localparam int PFN_W = 20;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             lookup_valid = 1'b0;
  logic [VPN_W-1:0] lookup_vpn = '0;
  logic             resp_valid, resp_hit, resp_pv;
  logic [PFN_W-1:0] resp_pfn;
  logic [2:0]       resp_perm;
  logic             fill = 1'b0;
  logic [VPN_W-1:0] fill_vpn = '0;
  logic [PFN_W-1:0] fill_pfn = '0;
  logic             fill_pv = 1'b0;
  logic [2:0]       fill_perm = '0;
  logic             flush = 1'b0;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  // behavioural model
  bit m_occ  [N];
  int m_vpn  [N];
  int m_pfn  [N];
  bit m_pv   [N];
  int m_perm [N];
  int m_rr = 0;
  bit e_valid, e_hit, e_pv;
  int e_pfn, e_perm;

  always #2.5 clk = ~clk;

  tlb_fa #(.ENTRIES(N), .VPN_W(VPN_W), .PFN_W(PFN_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .lookup_valid_i(lookup_valid), .lookup_vpn_i(lookup_vpn),
    .resp_valid_o(resp_valid), .resp_hit_o(resp_hit), .resp_pfn_o(resp_pfn),
    .resp_pv_o(resp_pv), .resp_perm_o(resp_perm),
    .fill_i(fill), .fill_vpn_i(fill_vpn), .fill_pfn_i(fill_pfn),
    .fill_pv_i(fill_pv), .fill_perm_i(fill_perm), .flush_i(flush)
  );

  task automatic check(string req);
    vectors++;
    if (resp_valid !== e_valid || resp_hit !== e_hit || resp_pfn !== PFN_W'(e_pfn) ||
        resp_pv !== e_pv || resp_perm !== 3'(e_perm)) begin
      miscompares++;
      $display("FAIL %s: got v=%0b h=%0b pfn=%0h pv=%0b perm=%0h exp v=%0b h=%0b pfn=%0h pv=%0b perm=%0h",
               req, resp_valid, resp_hit, resp_pfn, resp_pv, resp_perm,
               e_valid, e_hit, e_pfn, e_pv, e_perm);
    end
  endtask

  // called at a falling edge; drives one cycle and checks the registered result
  task automatic step(bit lv, int lvpn, bit fv, int fvpn, int fpfn, bit fpv, int fperm,
                      bit fl, string req);
    int hit_i = -1;
    int fm = -1;
    int free_i = -1;
    lookup_valid = lv; lookup_vpn = VPN_W'(lvpn);
    fill = fv; fill_vpn = VPN_W'(fvpn); fill_pfn = PFN_W'(fpfn);
    fill_pv = fpv; fill_perm = 3'(fperm); flush = fl;
    for (int i = 0; i < N; i++) if (m_occ[i] && m_vpn[i] == lvpn) hit_i = i;
    e_valid = lv;
    e_hit = lv && (hit_i >= 0);
    e_pfn = e_hit ? m_pfn[hit_i] : 0;
    e_pv = e_hit ? m_pv[hit_i] : 1'b0;
    e_perm = e_hit ? m_perm[hit_i] : 0;
    if (fl) begin
      for (int i = 0; i < N; i++) m_occ[i] = 1'b0;
    end else if (fv) begin
      int w;
      for (int i = 0; i < N; i++) if (m_occ[i] && m_vpn[i] == fvpn) fm = i;
      for (int i = N - 1; i >= 0; i--) if (!m_occ[i]) free_i = i;
      if (fm >= 0) w = fm;
      else if (free_i >= 0) w = free_i;
      else begin
        w = m_rr;
        m_rr = (m_rr + 1) % N;
      end
      m_occ[w] = 1'b1; m_vpn[w] = fvpn; m_pfn[w] = fpfn; m_pv[w] = fpv; m_perm[w] = fperm;
    end
    @(posedge clk);
    @(negedge clk);
    check(req);
  endtask

  task automatic look(int vpn, string req);
    step(1'b1, vpn, 1'b0, 0, 0, 1'b0, 0, 1'b0, req);
  endtask

  task automatic put(int vpn, int pfn, bit pv, int perm, string req);
    step(1'b0, 0, 1'b1, vpn, pfn, pv, perm, 1'b0, req);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) m_occ[i] = 1'b0;
    e_valid = 0; e_hit = 0; e_pfn = 0; e_pv = 0; e_perm = 0;
    repeat (3) @(negedge clk);
    check("R1");  // outputs zero in reset
    rst_n = 1'b1;
    @(negedge clk);
    check("R1");
    look(5, "R1");
    look(0, "R1");
    step(1'b0, 0, 1'b0, 0, 0, 1'b0, 0, 1'b0, "R4");  // idle cycle

    // basic fills and hits with varied permissions
    put(16'h100, 20'h0aaaa, 1'b1, 3'b100, "R5");
    put(16'h101, 20'h0bbbb, 1'b1, 3'b110, "R5");
    put(16'h102, 20'h0cccc, 1'b0, 3'b001, "R3");
    put(16'h103, 20'h0dddd, 1'b1, 3'b111, "R5");
    for (int v = 16'h100; v < 16'h104; v++) look(v, "R3");
    look(16'h104, "R4");

    // lookup and fill of same page in one cycle
    step(1'b1, 16'h200, 1'b1, 16'h200, 20'h12345, 1'b1, 3'b010, 1'b0, "R2");
    look(16'h200, "R2");

    // refill of a resident page
    put(16'h101, 20'h55555, 1'b0, 3'b011, "R7");
    look(16'h101, "R7");

    // fill to full
    for (int v = 0; v < N - 5; v++) put(16'h300 + v, 20'h30000 + v, 1'b1, v % 8, "R5");
    for (int v = 16'h100; v < 16'h104; v++) look(v, "R5");
    look(16'h200, "R5");
    for (int v = 0; v < N - 5; v++) look(16'h300 + v, "R5");

    // replacements
    put(16'h400, 20'h44440, 1'b1, 3'b101, "R6");
    look(16'h100, "R6");
    look(16'h101, "R6");
    put(16'h401, 20'h44441, 1'b1, 3'b101, "R6");
    look(16'h101, "R6");
    put(16'h102, 20'h66666, 1'b1, 3'b111, "R7");  // refill while full
    put(16'h402, 20'h44442, 1'b1, 3'b001, "R7");
    look(16'h102, "R7");
    look(16'h103, "R7");
    for (int v = 0; v < N + 3; v++) put(16'h500 + v, 20'h50000 + v, 1'b1, 3'b100, "R6");
    for (int v = 0; v < N + 3; v++) look(16'h500 + v, "R6");

    // flush with a fill in the same cycle
    step(1'b1, 16'h510, 1'b1, 16'h600, 20'h60000, 1'b1, 3'b111, 1'b1, "R8");
    look(16'h510, "R8");
    look(16'h600, "R8");
    look(16'h520, "R8");
    for (int v = 0; v < N + 2; v++) put(16'h700 + v, 20'h70000 + v, 1'b1, 3'b010, "R8");
    for (int v = 0; v < N + 2; v++) look(16'h700 + v, "R8");

    // random mix over a small page range
    for (int k = 0; k < 4000; k++) begin
      int r = $urandom_range(0, 99);
      step($urandom_range(0, 3) != 0, $urandom_range(0, 47),
           $urandom_range(0, 2) == 0, $urandom_range(0, 47), $urandom_range(0, 20'hfffff),
           1'($urandom_range(0, 1)), $urandom_range(0, 7), r == 0, "R6");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule